// File: doc/BRIEF.md
# Single-Precision Multiplier with Stale-MSB Fault Emulation

This block multiplies two single-precision floating-point operands and returns the product one clock later. It has a built-in path that emulates a timing miss on the slowest signal of the unit: the top bit of the 48-bit significand product. That bit decides whether the result is normalised by one extra place and whether the exponent sum is bumped by one. An injected fault therefore cannot produce an arbitrary corrupted word. It can only make the unit use a stale copy of that bit.

A register keeps the true product MSB of the last accepted operation. When the caller raises the fault strobe together with an operation, the unit compares the new MSB with the stored one. If the two are equal, a late signal would still have settled to the right value, so the correct product is returned. If they differ, the exponent is formed from the inverted bit. The result is then exactly twice the true product when the bit should have been 0, and exactly half of it when the bit should have been 1. The significand field and the sign do not change.

Special values are out of scope. An exponent field of zero is treated as an ordinary exponent with its hidden one. Rounding is by truncation, and any exponent that leaves the finite range is clamped.

Top module: `fpm_stale_msb`

## Requirements
- R1: `out_valid` is 0 during and after reset until an operation is accepted. Each cycle with `in_valid` high produces `out_valid` high with its result exactly one clock later. A cycle with `in_valid` low produces `out_valid` low one clock later.
- R2: Result bit 31 equals `op_a[31]` XOR `op_b[31]` for every result, including faulted and clamped results.
- R3: Let P be the product of `{1, op_a[22:0]}` and `{1, op_b[22:0]}`. When P bit 47 is 1 and there is no fault, result bits 22:0 are P[46:24] and the result exponent (bits 30:23) is Ea + Eb − 127 + 1, where Ea and Eb are operand bits 30:23.
- R4: When P bit 47 is 0 and there is no fault, result bits 22:0 are P[45:23] and the result exponent is Ea + Eb − 127.
- R5: If the final exponent would exceed 254, the magnitude is clamped to exponent 254 with all significand bits set, giving 0x7F7FFFFF with the sign ORed into bit 31.
- R6: If the final exponent would be below 1, the magnitude is clamped to exponent 1 with a zero significand, giving 0x00800000 with the sign ORed into bit 31.
- R7: With `fault_req` high, if P bit 47 equals the stored bit from the previous accepted operation, the result is the correct one.
- R8: With `fault_req` high, if P bit 47 differs from the stored bit, the exponent is built from the inverted bit. It is one higher than correct when the true bit is 0 and one lower when the true bit is 1. The significand bits stay those given by R3 or R4, and R5 and R6 then apply.
- R9: The stored bit is 0 after reset. It takes the true P bit 47 of every accepted operation, whether or not that operation was faulted.
- R10: `fault_req` and the operand inputs have no effect in a cycle with `in_valid` low. No result is produced and the stored bit is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is present this cycle |
| op_a | input | 32 | First operand (sign, 8-bit exponent, 23-bit fraction) |
| op_b | input | 32 | Second operand |
| fault_req | input | 1 | Emulated timing miss on this operation |
| out_valid | output | 1 | Result is present this cycle |
| out_res | output | 32 | Product |

## Verification
The bench builds the block with its default widths: an 8-bit exponent and a 23-bit fraction. At these widths the reference can form the 48-bit significand product in a plain 64-bit integer, and it can pick operand values whose product MSB is known in advance. Directed pairs walk the stored bit through every old/new combination with and without the fault strobe. They also drive exponent sums past both ends of the range, including a faulted clamp. A long pseudo-random run then mixes idle cycles, faults and both MSB outcomes, and is compared on every clock against the behavioural model.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    parameter int EXP_W_DEF = 8;
    parameter int MAN_W_DEF = 23;

    // what the fault path does to the exponent increment
    typedef enum logic [1:0] {
        CB_KEEP     = 2'd0,
        CB_FORCE_HI = 2'd1,
        CB_FORCE_LO = 2'd2
    } cb_action_e;

    function automatic cb_action_e cb_decide(input logic fault_on,
                                             input logic crit_now,
                                             input logic crit_prev);
        if (!fault_on || (crit_now == crit_prev))
            return CB_KEEP;
        else if (crit_now)
            return CB_FORCE_LO;
        else
            return CB_FORCE_HI;
    endfunction

endpackage

// File: rtl/fpm_sig_mul.sv
module fpm_sig_mul #(
    parameter int MAN_W = fpm_pkg::MAN_W_DEF
) (
    input  logic [MAN_W-1:0] frac_a,
    input  logic [MAN_W-1:0] frac_b,
    output logic [MAN_W:0]   prod_top,
    output logic             crit
);
    localparam int SIG_W  = MAN_W + 1;
    localparam int PROD_W = 2 * SIG_W;

    logic [SIG_W-1:0]  sig_a;
    logic [SIG_W-1:0]  sig_b;
    logic [PROD_W-1:0] prod;
    logic              unused_low;

    always_comb begin
        sig_a = {1'b1, frac_a};
        sig_b = {1'b1, frac_b};
        prod  = PROD_W'(sig_a) * PROD_W'(sig_b);
    end

    // MSB drives normalisation; the next MAN_W+1 bits hold both candidate fields
    assign crit       = prod[PROD_W-1];
    assign prod_top   = prod[PROD_W-2 -: MAN_W+1];
    assign unused_low = ^prod[PROD_W-MAN_W-3:0];

endmodule

// File: rtl/fpm_crit_track.sv
module fpm_crit_track
    import fpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       op_valid,
    input  logic       fault_req,
    input  logic       crit_now,
    output logic       prev_q,
    output cb_action_e action
);
    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b0;
        else if (op_valid)
            prev_q <= crit_now;
    end

    assign action = cb_decide(fault_req, crit_now, prev_q);

endmodule

// File: rtl/fpm_exp_norm.sv
module fpm_exp_norm
    import fpm_pkg::*;
#(
    parameter int EXP_W = EXP_W_DEF,
    parameter int MAN_W = MAN_W_DEF
) (
    input  logic [EXP_W-1:0] exp_a,
    input  logic [EXP_W-1:0] exp_b,
    input  logic [MAN_W:0]   prod_top,
    input  logic             crit,
    input  cb_action_e       action,
    output logic [EXP_W-1:0] exp_out,
    output logic [MAN_W-1:0] man_out
);
    localparam int EW2 = EXP_W + 2;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX = (1 << EXP_W) - 2;
    localparam logic signed [EW2-1:0] BIAS_S = EW2'(BIAS);
    localparam logic signed [EW2-1:0] EMAX_S = EW2'(EMAX);
    localparam logic signed [EW2-1:0] ONE_S  = EW2'(1);

    logic signed [EW2-1:0] e_base;
    logic signed [EW2-1:0] e_fin;
    logic [MAN_W-1:0]      man_norm;

    always_comb begin
        e_base = $signed({2'b00, exp_a}) + $signed({2'b00, exp_b}) - BIAS_S;
        unique case (action)
            CB_FORCE_HI: e_fin = e_base + ONE_S;
            CB_FORCE_LO: e_fin = e_base;
            default:     e_fin = e_base + (crit ? ONE_S : '0);
        endcase
        // significand always follows the true MSB
        man_norm = crit ? prod_top[MAN_W -: MAN_W] : prod_top[MAN_W-1:0];

        if (e_fin > EMAX_S) begin
            exp_out = EXP_W'(EMAX);
            man_out = '1;
        end else if (e_fin < ONE_S) begin
            exp_out = EXP_W'(1);
            man_out = '0;
        end else begin
            exp_out = e_fin[EXP_W-1:0];
            man_out = man_norm;
        end
    end

endmodule

// File: rtl/fpm_stale_msb.sv
module fpm_stale_msb
    import fpm_pkg::*;
#(
    parameter int EXP_W = EXP_W_DEF,
    parameter int MAN_W = MAN_W_DEF,
    localparam int WORD_W = 1 + EXP_W + MAN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              fault_req,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_res
);
    logic [MAN_W:0]   prod_top;
    logic             crit_now;
    logic             prev_q;
    cb_action_e       action;
    logic [EXP_W-1:0] exp_res;
    logic [MAN_W-1:0] man_res;
    logic             sign_res;

    fpm_sig_mul #(.MAN_W(MAN_W)) u_mul (
        .frac_a   (op_a[MAN_W-1:0]),
        .frac_b   (op_b[MAN_W-1:0]),
        .prod_top (prod_top),
        .crit     (crit_now)
    );

    fpm_crit_track u_trk (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (in_valid),
        .fault_req (fault_req),
        .crit_now  (crit_now),
        .prev_q    (prev_q),
        .action    (action)
    );

    fpm_exp_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
        .exp_a    (op_a[MAN_W +: EXP_W]),
        .exp_b    (op_b[MAN_W +: EXP_W]),
        .prod_top (prod_top),
        .crit     (crit_now),
        .action   (action),
        .exp_out  (exp_res),
        .man_out  (man_res)
    );

    assign sign_res = op_a[WORD_W-1] ^ op_b[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_res <= {sign_res, exp_res, man_res};
        end
    end

endmodule

// File: rtl/fpm_stale_msb_chk.sv
module fpm_stale_msb_chk #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int WORD_W = 1 + EXP_W + MAN_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_res,
    input logic              crit_now,
    input logic              prev_q
);
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_follow_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_sign_xor_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_res[WORD_W-1] == $past(op_a[WORD_W-1] ^ op_b[WORD_W-1]));

    p_exp_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_res[MAN_W +: EXP_W] != '1));

    p_exp_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_res[MAN_W +: EXP_W] != '0));

    p_prev_capture_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> prev_q == $past(crit_now));

    p_prev_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(prev_q));

endmodule

bind fpm_stale_msb fpm_stale_msb_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .out_res   (out_res),
    .crit_now  (crit_now),
    .prev_q    (prev_q)
);

// File: tb/sim_fpm_stale_msb.sv
`timescale 1ns/1ps
module sim_fpm_stale_msb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        fault_req = 1'b0;
    logic        out_valid;
    logic [31:0] out_res;

    int n_chk  = 0;
    int n_fail = 0;
    bit m_prev = 1'b0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fpm_stale_msb u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .fault_req(fault_req), .out_valid(out_valid), .out_res(out_res)
    );

    // behavioural reference for one operation
    function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                            input bit flt, input bit prv, output bit msb);
        logic [63:0] sa, sb, p;
        bit          eb;
        int          e;
        logic [22:0] m;
        logic        s;
        sa = {40'd0, 1'b1, a[22:0]};
        sb = {40'd0, 1'b1, b[22:0]};
        p = sa * sb;
        msb = p[47];
        eb = (flt && (msb != prv)) ? !msb : msb;
        e = int'(a[30:23]) + int'(b[30:23]) - 127 + int'(eb);
        m = msb ? p[46:24] : p[45:23];
        s = a[31] ^ b[31];
        if (e > 254)     return {s, 8'hFE, 23'h7FFFFF};
        else if (e < 1)  return {s, 8'h01, 23'h0};
        else             return {s, e[7:0], m};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b,
                        input bit f, input string tag);
        logic [31:0] exp_r;
        bit          msb;
        exp_r = '0;
        in_valid = v; op_a = a; op_b = b; fault_req = f;
        if (v) begin
            exp_r = ref_mul(a, b, f, m_prev, msb);
            m_prev = msb;
        end
        @(posedge clk);
        #1;
        chk(out_valid == v, {tag, " valid"}, {31'd0, out_valid}, {31'd0, v});
        if (v) chk(out_res == exp_r, tag, out_res, exp_r);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(out_valid == 1'b0, "R1 reset", {31'd0, out_valid}, 32'd0);
        rst = 1'b0;

        // R3: 1.5*1.5 = 2.25, MSB=1
        step(1, 32'h3FC00000, 32'h3FC00000, 0, "R3");
        chk(out_res == 32'h40100000, "R3 value", out_res, 32'h40100000);
        // R4: 2*3 = 6, MSB=0
        step(1, 32'h40000000, 32'h40400000, 0, "R4");
        chk(out_res == 32'h40C00000, "R4 value", out_res, 32'h40C00000);
        step(0, 32'h3FC00000, 32'h3FC00000, 1, "R1 idle");
        // R5 / R6 / R2 with clamping
        step(1, 32'h7F000000, 32'h7F000000, 0, "R5");
        chk(out_res == 32'h7F7FFFFF, "R5 value", out_res, 32'h7F7FFFFF);
        step(1, 32'hFF000000, 32'h7F000000, 0, "R2");
        chk(out_res == 32'hFF7FFFFF, "R2 clamp", out_res, 32'hFF7FFFFF);
        step(1, 32'h00800000, 32'h00800000, 0, "R6");
        chk(out_res == 32'h00800000, "R6 value", out_res, 32'h00800000);

        // stored bit now 0 (last MSB 0): reset-like state for the fault walk
        step(1, 32'h3FC00000, 32'h3FC00000, 1, "R8");
        chk(out_res == 32'h3F900000, "R8 half", out_res, 32'h3F900000);
        step(1, 32'h40000000, 32'h40400000, 1, "R8");
        chk(out_res == 32'h41400000, "R8 double", out_res, 32'h41400000);
        step(1, 32'h40000000, 32'h40400000, 1, "R7");
        chk(out_res == 32'h40C00000, "R7 same", out_res, 32'h40C00000);
        step(1, 32'h3FC00000, 32'h3FC00000, 0, "R9");
        // R10: faulted idle with opposite MSB operands must not move the stored bit
        step(0, 32'h40000000, 32'h40400000, 1, "R10");
        step(1, 32'h3FC00000, 32'h3FC00000, 1, "R10");
        chk(out_res == 32'h40100000, "R10 kept", out_res, 32'h40100000);
        step(1, 32'hC0000000, 32'h40400000, 1, "R2");
        chk(out_res == 32'hC1400000, "R2 fault sign", out_res, 32'hC1400000);
        // R9: faulted op still stores true MSB (0), so next MSB-0 fault is clean
        step(1, 32'h40000000, 32'h40400000, 1, "R9");
        chk(out_res == 32'h40C00000, "R9 true bit", out_res, 32'h40C00000);
        // faulted clamp
        step(1, 32'h7F7FFFFF, 32'h40000000, 1, "R8");
        chk(out_res == 32'h7F7FFFFF, "R8 clamp", out_res, 32'h7F7FFFFF);

        void'($urandom(32'd1234));
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] a, b;
            bit v, f;
            a = $urandom; b = $urandom;
            if (i % 3 != 0) begin
                a[30:23] = 8'd96 + 8'($urandom % 64);
                b[30:23] = 8'd96 + 8'($urandom % 64);
            end
            v = ($urandom % 5) != 0;
            f = ($urandom % 2) != 0;
            step(v, a, b, f, f ? "R8" : "R3");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule